// File: doc/BRIEF.md
# Dual-Modulus Fractional Feedback Divider

This block is the programmable feedback divider of a synthesizer loop. It runs on the VCO-rate clock. It behaves like a P/P+1 dual-modulus prescaler driven by a main counter M and a swallow counter A. The prescale value P is 32 on the high-band build and 16 on the low-band build. A 5-bit fractional accumulator adds F to itself once per division cycle. Each time it overflows, that cycle is one input clock longer, so the average division ratio is P·M + A + F/32.

The block emits a one-clock pulse at the end of every division cycle and exposes the modulus-control level. M, A and F come from a register bank. New values are captured only when a division cycle ends. A combinational flag reports settings that break channel continuity, either A above M or an integer ratio below P². The divider keeps running when the flag is set.

Top module: `fracn_fb_divider`

## Requirements
- R1: With F = 0 and A ≤ M, the distance between consecutive output pulses is exactly P·M + A input clocks.
- R2: Over any 32 consecutive division cycles, the total number of input clocks is 32·(P·M + A) + F.
- R3: Every single division cycle lasts either P·M + A or P·M + A + 1 input clocks, never anything else.
- R4: A non-zero F behaves as the reduced fraction (F/g)/(32/g), where g is the greatest common divisor of F and 32. Any window of 32/g consecutive cycles holds exactly F/g lengthened cycles.
- R5: With F = 0, `mod_ctl` is high for exactly min(A, M)·(P+1) input clocks of each division cycle.
- R6: `div_out` is high for exactly one input clock per division cycle, on the cycle's last clock.
- R7: A change of M, A or F in the middle of a division cycle does not alter that cycle. It takes effect from the next cycle onward.
- R8: `cfg_bad` is high whenever A > M.
- R9: `cfg_bad` is high when P·M + A < P². It is low when P·M + A ≥ P² and A ≤ M.
- R10: Settings that break the rules still divide. If A > M, all M prescaler periods are of P+1 clocks, giving (P+1)·M per cycle. An M of 0 is treated as 1.
- R11: While reset is held, `div_out` and `mod_ctl` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_m | input | M_W | Main counter value M |
| cfg_a | input | A_W | Swallow counter value A (0..31) |
| cfg_f | input | F_W | Fractional numerator F over 32 |
| div_out | output | 1 | One-clock pulse per division cycle |
| mod_ctl | output | 1 | High while the prescaler period is P+1 clocks |
| cfg_bad | output | 1 | Settings break a continuity rule |

## Verification
The hardest case to reach from the ports is a lengthened cycle that arrives exactly when the accumulator wraps. That cycle can only be told apart by measuring the spacing of pulses one cycle at a time, over a span long enough to cover the full repeat period of the fraction. The bench uses small M values, so 32 full cycles fit in a few thousand clocks. It records each pulse interval and checks the 32-cycle total, the length of each cycle, and the count of long cycles in every sliding window set by the reduced denominator. It does this for random (M, A, F) pairs and for directed fractions such as 12/32 and 8/32.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

   // number of extra input clocks added to a nominal P-clock period
   typedef logic [1:0] stretch_t;

   function automatic stretch_t stretch(input logic swallow, input logic extend);
      return stretch_t'({1'b0, swallow}) + stretch_t'({1'b0, extend});
   endfunction

endpackage

// File: rtl/fdiv_rule_check.sv
module fdiv_rule_check #(
   parameter int PRE = 32,
   parameter int M_W = 10,
   parameter int A_W = 5
) (
   input  logic [M_W-1:0] m,
   input  logic [A_W-1:0] a,
   output logic           bad
);
   localparam int R_W   = M_W + $clog2(PRE) + 2;
   localparam int FLOOR = PRE * PRE;

   logic [R_W-1:0] ratio;
   logic           swallow_high;
   logic           ratio_low;

   always_comb begin
      ratio        = R_W'(PRE) * R_W'(m) + R_W'(a);
      swallow_high = R_W'(a) > R_W'(m);
      ratio_low    = ratio < R_W'(FLOOR);
      bad          = swallow_high | ratio_low;
   end
endmodule

// File: rtl/fdiv_frac_acc.sv
module fdiv_frac_acc #(
   parameter int F_W = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [F_W-1:0] f,
   output logic           carry
);
   logic [F_W-1:0] acc;
   logic [F_W:0]   sum;

   always_comb begin
      sum   = {1'b0, acc} + {1'b0, f};
      carry = sum[F_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (load) acc <= sum[F_W-1:0];
   end

   // R2: with a zero numerator the accumulator must not move
   assert_acc_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && f == '0) |=> $stable(acc));
endmodule

// File: rtl/fdiv_prescale.sv
module fdiv_prescale #(
   parameter int PRE = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reload,
   input  fdiv_pkg::stretch_t  extra,
   output logic                period_end
);
   localparam int C_W = $clog2(PRE + 2);

   logic [C_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (reload) cnt <= C_W'(PRE - 1) + C_W'(extra);
      else             cnt <= cnt - 1'b1;
   end

   assign period_end = (cnt == '0);

   // R3: a period is never longer than P plus two stretch clocks
   assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= C_W'(PRE + 1));
endmodule

// File: rtl/fdiv_cycle_seq.sv
module fdiv_cycle_seq #(
   parameter int M_W = 10,
   parameter int A_W = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [M_W-1:0]      m,
   input  logic [A_W-1:0]      a,
   input  logic                carry,
   input  logic                period_end,
   output logic                load,
   output logic                reload,
   output fdiv_pkg::stretch_t  extra,
   output logic                cycle_end,
   output logic                mod_ctl
);
   logic           run;
   logic [M_W-1:0] per_left;
   logic [A_W-1:0] sw_left;
   logic           ext;
   logic [M_W-1:0] m_eff;
   logic [A_W-1:0] a_eff;
   logic [A_W-1:0] nsw;
   logic           last;

   always_comb begin
      m_eff     = (m == '0) ? M_W'(1) : m;
      a_eff     = (M_W'(a) > m_eff) ? A_W'(m_eff) : a;
      nsw       = sw_left - A_W'(sw_left != '0);
      last      = (per_left == M_W'(1));
      cycle_end = run && period_end && last;
      load      = !run || cycle_end;
      reload    = !run || period_end;
      if (load) extra = fdiv_pkg::stretch(a_eff != '0, (m_eff == M_W'(1)) && carry);
      else      extra = fdiv_pkg::stretch(nsw != '0, (per_left == M_W'(2)) && ext);
      mod_ctl   = run && (sw_left != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         per_left <= '0;
         sw_left  <= '0;
         ext      <= 1'b0;
      end else if (load) begin
         run      <= 1'b1;
         per_left <= m_eff;
         sw_left  <= a_eff;
         ext      <= carry;
      end else if (period_end) begin
         per_left <= per_left - 1'b1;
         sw_left  <= nsw;
      end
   end

   // R10: swallow periods never outnumber the periods left
   assert_swallow_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (M_W'(sw_left) <= per_left));
   // R6: the output pulse is one clock wide
   assert_pulse_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_end |=> !cycle_end);
   // R7: counters hold between period boundaries
   assert_hold_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !period_end) |=> ($stable(per_left) && $stable(sw_left) && $stable(ext)));
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider #(
   parameter bit HIGH_BAND = 1'b1,
   parameter int M_W       = 10,
   parameter int A_W       = 5,
   parameter int F_W       = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] cfg_m,
   input  logic [A_W-1:0] cfg_a,
   input  logic [F_W-1:0] cfg_f,
   output logic           div_out,
   output logic           mod_ctl,
   output logic           cfg_bad
);
   localparam int PRE = HIGH_BAND ? 32 : 16;

   generate
      if (M_W < A_W) begin : g_chk_mw
         $error("M_W must be at least A_W");
      end
      if (A_W > $clog2(PRE) + 1) begin : g_chk_aw
         $error("A_W too wide for the prescale value");
      end
      if (F_W < 1) begin : g_chk_fw
         $error("F_W must be positive");
      end
   endgenerate

   logic               load;
   logic               reload;
   logic               carry;
   logic               period_end;
   fdiv_pkg::stretch_t extra;

   fdiv_frac_acc #(.F_W(F_W)) i_acc (
      .clk(clk), .rst_n(rst_n), .load(load), .f(cfg_f), .carry(carry));

   fdiv_prescale #(.PRE(PRE)) i_pre (
      .clk(clk), .rst_n(rst_n), .reload(reload), .extra(extra),
      .period_end(period_end));

   fdiv_cycle_seq #(.M_W(M_W), .A_W(A_W)) i_seq (
      .clk(clk), .rst_n(rst_n), .m(cfg_m), .a(cfg_a), .carry(carry),
      .period_end(period_end), .load(load), .reload(reload), .extra(extra),
      .cycle_end(div_out), .mod_ctl(mod_ctl));

   fdiv_rule_check #(.PRE(PRE), .M_W(M_W), .A_W(A_W)) i_rule (
      .m(cfg_m), .a(cfg_a), .bad(cfg_bad));

   // R8: a swallow count above the main count is always flagged
   assert_flag_swallow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ({{(M_W-A_W){1'b0}}, cfg_a} > cfg_m) |-> cfg_bad);
endmodule

// File: tb/test_fracn_fb_divider.sv
module test_fracn_fb_divider;
   localparam int P   = 32;
   localparam int M_W = 10;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [M_W-1:0] cfg_m = '0;
   logic [4:0]     cfg_a = '0;
   logic [4:0]     cfg_f = '0;
   logic           div_out, mod_ctl, cfg_bad;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   fracn_fb_divider #(.HIGH_BAND(1'b1), .M_W(M_W)) i_fracn_fb_divider (
      .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_a(cfg_a), .cfg_f(cfg_f),
      .div_out(div_out), .mod_ctl(mod_ctl), .cfg_bad(cfg_bad));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int gcd32(input int f);
      int g = 32;
      while (g > 1 && (f % g) != 0) g = g / 2;
      return g;
   endfunction

   function automatic int min_ma(input int m, input int a);
      int me = (m == 0) ? 1 : m;
      return (a > me) ? me : a;
   endfunction

   function automatic bit expect_bad(input int m, input int a);
      return (a > m) || (P * m + a < P * P);
   endfunction

   task automatic sync_pulse();
      do @(negedge clk); while (!div_out);
   endtask

   task automatic next_interval(output int len, output int mc);
      len = 0; mc = 0;
      do begin
         @(negedge clk);
         len++;
         if (mod_ctl) mc++;
      end while (!div_out);
   endtask

   task automatic set_cfg(input int m, input int a, input int f);
      cfg_m = M_W'(m); cfg_a = 5'(a); cfg_f = 5'(f);
   endtask

   task automatic run_frac(input int m, input int a, input int f);
      int lens[32];
      int sum = 0, odd = 0, mc, base, g, w, k, winbad = 0;
      set_cfg(m, a, f);
      sync_pulse();
      base = P * m + a;
      for (int i = 0; i < 32; i++) begin
         next_interval(lens[i], mc);
         sum += lens[i];
         if (lens[i] != base && lens[i] != base + 1) odd++;
      end
      check(sum == 32 * base + f, "R2 32-cycle total", sum, 32 * base + f);
      check(odd == 0, "R3 cycle length off by more than one", odd, 0);
      if (f != 0) begin
         g = gcd32(f); w = 32 / g; k = f / g;
         for (int s = 0; s + w <= 32; s++) begin
            int c = 0;
            for (int j = s; j < s + w; j++) if (lens[j] == base + 1) c++;
            if (c != k) winbad++;
         end
         check(winbad == 0, "R4 reduced-fraction windows", winbad, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int len, mc, seed;
      seed = $urandom(7);
      set_cfg(4, 0, 0);
      repeat (3) @(negedge clk);
      // R11 reset state
      check(div_out == 1'b0, "R11 div_out in reset", int'(div_out), 0);
      check(mod_ctl == 1'b0, "R11 mod_ctl in reset", int'(mod_ctl), 0);
      rst_n = 1'b1;

      // R1 integer ratio
      set_cfg(5, 3, 0); sync_pulse(); next_interval(len, mc);
      check(len == 163, "R1 interval M=5 A=3", len, 163);
      // R5 modulus-control clocks
      check(mc == 3 * (P + 1), "R5 mod_ctl clocks", mc, 3 * (P + 1));
      set_cfg(2, 0, 0); sync_pulse(); next_interval(len, mc);
      check(len == 64, "R1 interval M=2 A=0", len, 64);
      check(mc == 0, "R5 mod_ctl idle with A=0", mc, 0);

      // R7 mid-cycle change
      set_cfg(4, 0, 0); sync_pulse(); sync_pulse();
      len = 0;
      do begin
         @(negedge clk); len++;
         if (len == 10) set_cfg(2, 0, 0);
      end while (!div_out);
      check(len == 128, "R7 current cycle kept", len, 128);
      next_interval(len, mc);
      check(len == 64, "R7 new value next cycle", len, 64);

      // R10 rule-breaking settings keep dividing
      set_cfg(3, 7, 0); sync_pulse(); next_interval(len, mc);
      check(len == 3 * (P + 1), "R10 A>M ratio", len, 3 * (P + 1));
      check(cfg_bad == 1'b1, "R8 flag on A>M", int'(cfg_bad), 1);
      set_cfg(0, 0, 0); sync_pulse(); next_interval(len, mc);
      check(len == P, "R10 M=0 as 1", len, P);

      // R9 ratio floor
      set_cfg(31, 31, 0); #2;
      check(cfg_bad == expect_bad(31, 31), "R9 ratio 1023 flagged", int'(cfg_bad), 1);
      set_cfg(32, 0, 0); #2;
      check(cfg_bad == expect_bad(32, 0), "R9 ratio 1024 clean", int'(cfg_bad), 0);
      set_cfg(32, 31, 0); #2;
      check(cfg_bad == 1'b0, "R9 A at max clean", int'(cfg_bad), 0);
      @(negedge clk);

      // directed fractions (R2 R3 R4)
      run_frac(2, 1, 12);
      run_frac(3, 2, 8);
      run_frac(1, 1, 31);
      // constrained random
      for (int i = 0; i < 6; i++) begin
         int m = 1 + int'($urandom % 8);
         int a = int'($urandom % (m + 1));
         int f = int'($urandom % 32);
         #2;
         check(cfg_bad == expect_bad(int'(cfg_m), int'(cfg_a)), "R9 flag on held setting",
               int'(cfg_bad), int'(expect_bad(int'(cfg_m), int'(cfg_a))));
         run_frac(m, a, min_ma(m, a) == a ? f : 0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule